// File: doc/BRIEF.md
# Inter-Block Silence Activity Checker

This block decides whether the stretch of tape between two recorded data blocks was really quiet. Once the first block has been read, a start pulse arms it. It then takes a fixed number of tape samples, one per sample-enable pulse. It counts how often the tape level changes, window by window. At the end it compares the activity near the beginning of the gap with the activity near its end.

A true silent gap shows about the same small amount of activity at both ends. A gap that has been shortened or filled shows a different count at the two ends, or heavy activity at the end. Either case raises a fail flag. The flag stays set until the next start. The surrounding loader reads the flag once done is high and uses it to refuse the second block.

The block keeps one saturating counter for the current window and two running sums: the early span and the late span. It does not store the count of every window.

Top module: `sil_gap_monitor`

## Requirements
- R1: After reset, done and fail are both 0.
- R2: A start pulse makes done and fail read 0 from the next clock. It begins a new run from the first window, even if a run is already in progress. A sample enable in the same cycle as start is not taken.
- R3: A run takes exactly NUM_WIN*WIN_LEN samples, which is 65025 with the defaults (255 windows of 255 samples). Only clocks with smp_en high are samples, and tape_in in any other clock has no effect. done reads 1 two clocks after the clock that takes the last sample, and reads 0 one clock after it.
- R4: A transition is a sample whose level differs from the previously taken sample of the same run. The level carries across window boundaries. The first sample of a run never counts as a transition, whatever the tape level was before start.
- R5: The early sum A is the total of the window counts of windows 0 to SPAN-1 (0..49 by default). Windows between the two spans have no effect on the result.
- R6: The late sum B is the total of the window counts of the last SPAN windows (205..254 by default).
- R7: fail is 1 when B is at least CEIL (256 by default), whatever A is.
- R8: When B is below CEIL, fail is 1 exactly when |B-A| is at least TOL (50 by default). A difference of TOL-1 passes.
- R9: The count of each window saturates at 2**CNT_W-1 (255 by default) before it is added to a sum.
- R10: After done rises, done and fail hold their values until the next start. fail is never 1 while done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-clock pulse that clears the result and begins a run |
| smp_en | input | 1 | Marks the clocks in which tape_in is a sample |
| tape_in | input | 1 | Tape input level |
| done | output | 1 | Run complete; fail is valid while this is high |
| fail | output | 1 | Sticky result: the gap was not judged silent |

## Verification
The bench goes after the tolerance and ceiling edges: a difference of exactly TOL-1 against exactly TOL, and a late sum one below and exactly at the ceiling. An off-by-one comparator flips one of these results. Heavy activity placed only in the middle windows must still pass, so a design with the wrong span bounds fails there. A window that toggles more than the saturation limit on the early side is balanced only after clamping, so an unclamped design reports a fail. Other runs start high from a cleared tracker, are restarted midway, or have idle clocks filled with noise. These catch a phantom first transition, leftover state and samples taken without an enable. Each run also checks that done rises on the expected clock.

// File: rtl/sil_chk_pkg.sv
package sil_chk_pkg;

    localparam int DEF_WIN_LEN = 255;
    localparam int DEF_NUM_WIN = 255;
    localparam int DEF_SPAN    = 50;
    localparam int DEF_TOL     = 50;
    localparam int DEF_CEIL    = 256;
    localparam int DEF_CNT_W   = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_JUDGE = 2'd2
    } run_state_e;

    // One taken sample and whether it changed level
    typedef struct packed {
        logic valid;
        logic toggled;
    } tick_t;

    typedef struct packed {
        logic ceil_hit;
        logic drift_hit;
    } verdict_t;

    function automatic verdict_t judge(input int unsigned early,
                                       input int unsigned late,
                                       input int unsigned tol,
                                       input int unsigned ceil_lim);
        verdict_t    v;
        int unsigned diff;
        diff        = (late >= early) ? (late - early) : (early - late);
        v.ceil_hit  = (late >= ceil_lim);
        v.drift_hit = (diff >= tol);
        return v;
    endfunction

endpackage

// File: rtl/sil_level_track.sv
module sil_level_track
    import sil_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  step,
    input  logic  tape,
    output tick_t tick
);

    logic level;
    logic primed;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            level  <= 1'b0;
            primed <= 1'b0;
        end else if (step) begin
            level  <= tape;
            primed <= 1'b1;
        end
    end

    always_comb begin
        tick.valid   = step;
        tick.toggled = step && primed && (tape != level);
    end

endmodule

// File: rtl/sil_window_tally.sv
module sil_window_tally
    import sil_chk_pkg::*;
#(
    parameter int WIN_LEN = DEF_WIN_LEN,
    parameter int NUM_WIN = DEF_NUM_WIN,
    parameter int CNT_W   = DEF_CNT_W,
    localparam int SIDX_W = $clog2(WIN_LEN),
    localparam int WIDX_W = $clog2(NUM_WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  tick_t             tick,
    output logic              win_close,
    output logic              last_win,
    output logic [WIDX_W-1:0] win_idx,
    output logic [CNT_W-1:0]  win_total
);

    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [SIDX_W-1:0] SIDX_END = SIDX_W'(WIN_LEN - 1);
    localparam logic [WIDX_W-1:0] WIDX_END = WIDX_W'(NUM_WIN - 1);

    logic [SIDX_W-1:0] smp_idx;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_next;

    always_comb begin
        cnt_next  = (tick.toggled && (cnt != CNT_MAX)) ? cnt + 1'b1 : cnt;
        win_close = tick.valid && (smp_idx == SIDX_END);
        last_win  = win_close && (win_idx == WIDX_END);
        win_total = cnt_next;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            smp_idx <= '0;
            win_idx <= '0;
            cnt     <= '0;
        end else if (tick.valid) begin
            if (smp_idx == SIDX_END) begin
                smp_idx <= '0;
                cnt     <= '0;
                win_idx <= win_idx + 1'b1;
            end else begin
                smp_idx <= smp_idx + 1'b1;
                cnt     <= cnt_next;
            end
        end
    end

endmodule

// File: rtl/sil_span_sum.sv
module sil_span_sum
    import sil_chk_pkg::*;
#(
    parameter int NUM_WIN = DEF_NUM_WIN,
    parameter int SPAN    = DEF_SPAN,
    parameter int CNT_W   = DEF_CNT_W,
    localparam int WIDX_W = $clog2(NUM_WIN),
    localparam int SUM_W  = $clog2(SPAN * (2**CNT_W - 1) + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  logic                      win_close,
    input  logic [WIDX_W-1:0]         win_idx,
    input  logic [CNT_W-1:0]          win_total,
    output logic [1:0][SUM_W-1:0]     sums
);

    // bank 0 covers the leading span, bank 1 the trailing span
    for (genvar g = 0; g < 2; g++) begin : g_bank
        localparam int LO = (g == 0) ? 0 : NUM_WIN - SPAN;
        logic [SUM_W-1:0] acc;
        logic             hit;

        assign hit = win_close && (int'(win_idx) >= LO) && (int'(win_idx) < LO + SPAN);

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                acc <= '0;
            end else if (hit) begin
                acc <= acc + SUM_W'(win_total);
            end
        end

        assign sums[g] = acc;
    end

endmodule

// File: rtl/sil_gap_monitor.sv
module sil_gap_monitor
    import sil_chk_pkg::*;
#(
    parameter int WIN_LEN = DEF_WIN_LEN,
    parameter int NUM_WIN = DEF_NUM_WIN,
    parameter int SPAN    = DEF_SPAN,
    parameter int TOL     = DEF_TOL,
    parameter int CEIL    = DEF_CEIL,
    parameter int CNT_W   = DEF_CNT_W
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic smp_en,
    input  logic tape_in,
    output logic done,
    output logic fail
);

    localparam int WIDX_W = $clog2(NUM_WIN);
    localparam int SUM_W  = $clog2(SPAN * (2**CNT_W - 1) + 1);

    run_state_e            state;
    logic                  running;
    logic                  step;
    tick_t                 tick;
    logic                  win_close;
    logic                  last_win;
    logic [WIDX_W-1:0]     win_idx;
    logic [CNT_W-1:0]      win_total;
    logic [1:0][SUM_W-1:0] sums;
    verdict_t              verdict;

    assign running = (state == ST_RUN);
    assign step    = smp_en && running && !start;

    sil_level_track u_track (
        .clk  (clk),
        .rst  (rst),
        .clr  (start),
        .step (step),
        .tape (tape_in),
        .tick (tick)
    );

    sil_window_tally #(
        .WIN_LEN (WIN_LEN),
        .NUM_WIN (NUM_WIN),
        .CNT_W   (CNT_W)
    ) u_tally (
        .clk       (clk),
        .rst       (rst),
        .clr       (start),
        .tick      (tick),
        .win_close (win_close),
        .last_win  (last_win),
        .win_idx   (win_idx),
        .win_total (win_total)
    );

    sil_span_sum #(
        .NUM_WIN (NUM_WIN),
        .SPAN    (SPAN),
        .CNT_W   (CNT_W)
    ) u_sums (
        .clk       (clk),
        .rst       (rst),
        .clr       (start),
        .win_close (win_close),
        .win_idx   (win_idx),
        .win_total (win_total),
        .sums      (sums)
    );

    assign verdict = judge(32'(sums[0]), 32'(sums[1]),
                           32'(TOL), 32'(CEIL));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else if (start) begin
            state <= ST_RUN;
            done  <= 1'b0;
            fail  <= 1'b0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    if (last_win) state <= ST_JUDGE;
                end
                ST_JUDGE: begin
                    done  <= 1'b1;
                    fail  <= verdict.ceil_hit || verdict.drift_hit;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sil_gap_monitor_chk.sv
module sil_gap_monitor_chk #(
    parameter int TOTAL = 65025
) (
    input logic clk,
    input logic rst,
    input logic start,
    input logic smp_en,
    input logic busy,
    input logic done,
    input logic fail
);

    logic [31:0] taken;

    always_ff @(posedge clk) begin
        if (rst || start) taken <= '0;
        else if (smp_en && busy) taken <= taken + 1'b1;
    end

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!done && !fail));

    // R3
    sample_total_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (taken == 32'(TOTAL)));

    // R10
    fail_gated_chk: assert property (@(posedge clk) disable iff (rst)
        fail |-> done);

    // R10
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R10
    fail_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(fail));

endmodule

bind sil_gap_monitor sil_gap_monitor_chk #(
    .TOTAL (NUM_WIN * WIN_LEN)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .smp_en (smp_en),
    .busy   (running),
    .done   (done),
    .fail   (fail)
);

// File: tb/sil_gap_monitor_tb_top.sv
module sil_gap_monitor_tb_top;

    localparam int CLK_PERIOD = 10;

    // unit 0: default sizes, unit 1: reduced sizes
    localparam int WL  [2] = '{255, 16};
    localparam int NW  [2] = '{255, 20};
    localparam int SP  [2] = '{50, 4};
    localparam int TL  [2] = '{50, 6};
    localparam int CL  [2] = '{256, 20};
    localparam int SAT [2] = '{255, 7};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_s [2];
    logic smp_s   [2];
    logic tape_s  [2];
    logic done_s  [2];
    logic fail_s  [2];

    int  n_chk = 0;
    int  n_err = 0;
    bit  exp_q0 [$];
    bit  exp_q1 [$];
    bit  finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sil_gap_monitor dut_i (
        .clk (clk), .rst (rst), .start (start_s[0]), .smp_en (smp_s[0]),
        .tape_in (tape_s[0]), .done (done_s[0]), .fail (fail_s[0])
    );

    sil_gap_monitor #(
        .WIN_LEN (16), .NUM_WIN (20), .SPAN (4), .TOL (6), .CEIL (20), .CNT_W (3)
    ) dut_s (
        .clk (clk), .rst (rst), .start (start_s[1]), .smp_en (smp_s[1]),
        .tape_in (tape_s[1]), .done (done_s[1]), .fail (fail_s[1])
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    // monitor: pop one expected verdict per rising done
    initial begin
        bit seen [2];
        seen = '{0, 0};
        forever begin
            @(negedge clk);
            for (int u = 0; u < 2; u++) begin
                if (done_s[u] && !seen[u]) begin
                    bit e;
                    if (u == 0 && exp_q0.size() > 0) e = exp_q0.pop_front();
                    else if (u == 1 && exp_q1.size() > 0) e = exp_q1.pop_front();
                    else e = 1'bx;
                    chk(fail_s[u] === e, $sformatf("R7/R8 verdict unit%0d", u),
                        int'(fail_s[u]), int'(e));
                end
                seen[u] = done_s[u];
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic pulse_start(input int u);
        start_s[u] = 1'b1;
        @(negedge clk);
        start_s[u] = 1'b0;
    endtask

    // drive one full run; tog[w] = toggle positions at the head of window w
    task automatic run_case(input int u, input int tog[], input bit first_lvl,
                            input bit gaps, input string tag);
        int total, wcnt, sa, sb, diff;
        bit b, prev, e;
        total = WL[u] * NW[u];
        b = first_lvl; prev = first_lvl;
        wcnt = 0; sa = 0; sb = 0;
        for (int s = 0; s < total; s++) begin
            int w, pos;
            w = s / WL[u]; pos = s % WL[u];
            if (s > 0 && pos < tog[w]) b = ~b;
            if (s > 0 && b != prev) wcnt++;
            prev = b;
            if (pos == WL[u] - 1) begin
                int c;
                c = (wcnt > SAT[u]) ? SAT[u] : wcnt;
                if (w < SP[u]) sa += c;
                if (w >= NW[u] - SP[u]) sb += c;
                wcnt = 0;
            end
        end
        diff = (sb > sa) ? sb - sa : sa - sb;
        e = (sb >= CL[u]) || (diff >= TL[u]);
        if (u == 0) exp_q0.push_back(e); else exp_q1.push_back(e);

        pulse_start(u);
        // R2: cleared after start
        chk(done_s[u] == 1'b0 && fail_s[u] == 1'b0, {"R2 clear ", tag},
            int'(done_s[u]) + int'(fail_s[u]), 0);
        b = first_lvl;
        for (int s = 0; s < total; s++) begin
            int w, pos;
            w = s / WL[u]; pos = s % WL[u];
            if (s > 0 && pos < tog[w]) b = ~b;
            if (gaps && ($urandom % 3 == 0)) begin
                smp_s[u]  = 1'b0;
                tape_s[u] = 1'($urandom);
                @(negedge clk);
            end
            smp_s[u]  = 1'b1;
            tape_s[u] = b;
            @(negedge clk);
        end
        smp_s[u] = 1'b0;
        tape_s[u] = 1'b0;
        // R3: done one clock late, then high
        chk(done_s[u] == 1'b0, {"R3 early done ", tag}, int'(done_s[u]), 0);
        @(negedge clk);
        chk(done_s[u] == 1'b1, {"R3 done ", tag}, int'(done_s[u]), 1);
        repeat (3) @(negedge clk);
        // R10: result held
        chk(done_s[u] == 1'b1 && fail_s[u] == e, {"R10 hold ", tag},
            int'(fail_s[u]), int'(e));
    endtask

    initial begin
        int t[];
        for (int u = 0; u < 2; u++) begin
            start_s[u] = 0; smp_s[u] = 0; tape_s[u] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        for (int u = 0; u < 2; u++)
            // R1
            chk(done_s[u] == 0 && fail_s[u] == 0, "R1 reset",
                int'(done_s[u]) + int'(fail_s[u]), 0);

        // reduced unit
        t = new[20];
        run_case(1, t, 1'b0, 1'b0, "quiet R4");
        t = new[20]; t[1] = 5;
        run_case(1, t, 1'b0, 1'b0, "diff TOL-1 R8");
        t = new[20]; t[1] = 6;
        run_case(1, t, 1'b0, 1'b0, "diff TOL R8");
        t = new[20]; for (int w = 4; w < 16; w++) t[w] = 15;
        run_case(1, t, 1'b0, 1'b0, "middle busy R5");
        t = new[20]; t[17] = 6;
        run_case(1, t, 1'b0, 1'b0, "late only R6");
        t = new[20]; t[1] = 7; t[2] = 7; t[3] = 5; t[16] = 7; t[17] = 7; t[18] = 5;
        run_case(1, t, 1'b0, 1'b0, "ceil-1 R7");
        t = new[20]; t[1] = 7; t[2] = 7; t[3] = 6; t[16] = 7; t[17] = 7; t[18] = 6;
        run_case(1, t, 1'b0, 1'b0, "ceil R7");
        t = new[20]; t[1] = 15; t[16] = 7;
        run_case(1, t, 1'b0, 1'b0, "saturate R9");
        t = new[20]; t[1] = 5;
        run_case(1, t, 1'b1, 1'b0, "first high R4");
        t = new[20]; t[1] = 5;
        run_case(1, t, 1'b0, 1'b1, "gaps pass R3");
        t = new[20]; t[1] = 6;
        run_case(1, t, 1'b0, 1'b1, "gaps fail R3");
        // R2: restart midway through a noisy run
        pulse_start(1);
        for (int s = 0; s < 100; s++) begin
            smp_s[1] = 1'b1; tape_s[1] = 1'($urandom);
            @(negedge clk);
        end
        smp_s[1] = 1'b0;
        t = new[20];
        run_case(1, t, 1'b0, 1'b0, "restart R2");

        // default unit
        t = new[255]; t[49] = 49; t[50] = 200; t[204] = 200;
        run_case(0, t, 1'b0, 1'b0, "default pass R5 R8");
        t = new[255]; t[254] = 50;
        run_case(0, t, 1'b0, 1'b0, "default late R6 R8");

        repeat (2) @(negedge clk);
        chk(exp_q0.size() == 0 && exp_q1.size() == 0, "R3 all runs done",
            exp_q0.size() + exp_q1.size(), 0);
        summary();
    end

endmodule